// File: doc/BRIEF.md
# Slot-Table Barrel Thread Scheduler

This block chooses, every clock cycle, which hardware thread may send one instruction into a single-issue pipeline that has no bypass paths. Threads take turns so that consecutive instructions in flight come from different contexts. A programmable table of issue slots says which thread owns each slot. A pointer walks the slots in a fixed circular order. In each cycle the block issues the owner of the current slot if that thread says it is ready. If the owner is not ready, the slot is lost as a bubble and is never handed to another thread.

The chosen thread number leaves the block in a register next to a valid flag. Later pipeline stages use it to select per-thread state. Software rewrites the table through a simple write port. A write is held in a shadow copy until the pointer returns to slot 0, so a rotation that has already started runs to its end on the old mapping. Per-thread counters of issued slots and lost slots show how the pipeline bandwidth is shared. A table state machine has two states. `TBL_SYNCED` means the shadow and live tables match. `TBL_PENDING` means a write is waiting. A write moves it from SYNCED to PENDING (transition *stage*). A commit at the slot-0 boundary moves it back to SYNCED (transition *commit*). A write in the commit cycle itself is committed at once.

Top module: `barrel_slot_sched`

## Requirements
- R1: After reset, `issue_valid` is 0 and `issue_tid` is 0. All counters are 0 and the pointer is at slot 0. The table holds the default mapping: slot i is owned by thread i mod 4, with every slot enabled.
- R2: On each rising edge with `run_en` high, the slot under the pointer is evaluated and the pointer then moves to the next slot, wrapping from 7 to 0. With the default table and all threads ready, issue goes 0,1,2,3,0,… and each thread issues exactly once every 4 cycles.
- R3: If the owner of an enabled slot has its `thr_ready` bit low, the slot produces a bubble. No other thread is issued in its place. On any bubble, `issue_tid` is 0.
- R4: The outputs are registered. The `thr_ready` value present at a rising edge decides the `issue_valid`/`issue_tid` that appear just after that edge.
- R5: While `run_en` is low, every cycle is a bubble and the pointer does not move.
- R6: A write uses `tbl_wr_idx` (slot 0..7), `tbl_wr_tid` (thread 0..3) and `tbl_wr_on` (1 = slot enabled). An enabled slot whose owner is ready issues that owner. A disabled slot always gives a bubble.
- R7: A write becomes live at the first rising edge where the pointer will be at slot 0 afterwards. That edge is either the wrap from slot 7 while running, or any edge while stopped at slot 0. Slots still left in the current rotation use the old mapping.
- R8: One thread may own several slots or none. A thread with no slots never issues, even when it is the only ready thread.
- R9: `cnt_issue` field t (bits 16t+15..16t) counts the cycles in which thread t issued. `cnt_bubble` field t counts enabled slots owned by thread t that were lost because t was not ready. Disabled slots and stopped cycles add to no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Advance the slot pointer and allow issue |
| thr_ready | input | 4 | Per-thread ready flags, bit t for thread t |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_idx | input | 3 | Slot index to write |
| tbl_wr_tid | input | 2 | Owning thread for that slot |
| tbl_wr_on | input | 1 | Slot enable for that slot |
| issue_valid | output | 1 | An instruction from `issue_tid` issues this cycle |
| issue_tid | output | 2 | Issuing thread; 0 on a bubble |
| cnt_issue | output | 64 | Four 16-bit per-thread issue counters |
| cnt_bubble | output | 64 | Four 16-bit per-thread lost-slot counters |

## Verification
The checker assumes that `thr_ready` and `run_en` are stable around the rising edge. It also assumes the counters do not wrap within a run. The bench drives every input on the falling edge, and each test is far shorter than 65536 cycles. The checker also assumes that a thread flagged ready at the edge was ready when its slot was judged. It holds a registered copy of `thr_ready` for this reason. The bench only changes ready flags between edges, so that copy is exact.

// File: rtl/barrel_slot_sched_pkg.sv
package barrel_slot_sched_pkg;

    typedef enum logic {
        TBL_SYNCED  = 1'b0,
        TBL_PENDING = 1'b1
    } tbl_state_e;

endpackage

// File: rtl/bss_slot_pointer.sv
module bss_slot_pointer #(
    parameter int NUM_SLOTS = 8,
    localparam int SW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    output logic [SW-1:0] slot_idx,
    output logic          at_boundary
);

    localparam logic [SW-1:0] LAST = SW'(NUM_SLOTS - 1);

    logic [SW-1:0] slot_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else if (run_en) begin
            slot_q <= (slot_q == LAST) ? '0 : slot_q + 1'b1;
        end
    end

    // The pointer will rest on slot 0 after this edge
    assign at_boundary = run_en ? (slot_q == LAST) : (slot_q == '0);
    assign slot_idx    = slot_q;

endmodule

// File: rtl/bss_slot_table.sv
module bss_slot_table
    import barrel_slot_sched_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int NUM_SLOTS   = 8,
    localparam int SW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int TW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_idx,
    input  logic [TW-1:0] wr_tid,
    input  logic          wr_on,
    input  logic          commit,
    input  logic [SW-1:0] rd_idx,
    output logic [TW-1:0] rd_tid,
    output logic          rd_on
);

    tbl_state_e    state_q, state_d;
    logic [TW-1:0] shd_tid [NUM_SLOTS];
    logic          shd_on  [NUM_SLOTS];
    logic [TW-1:0] act_tid [NUM_SLOTS];
    logic          act_on  [NUM_SLOTS];
    logic [TW-1:0] nxt_tid [NUM_SLOTS];
    logic          nxt_on  [NUM_SLOTS];
    logic          do_copy;

    // Shadow contents including this cycle's write
    always_comb begin
        for (int s = 0; s < NUM_SLOTS; s++) begin
            nxt_tid[s] = shd_tid[s];
            nxt_on[s]  = shd_on[s];
        end
        if (wr_en) begin
            nxt_tid[wr_idx] = wr_tid;
            nxt_on[wr_idx]  = wr_on;
        end
    end

    // Next-state logic for the table synchronisation FSM
    always_comb begin
        state_d = state_q;
        do_copy = 1'b0;
        unique case (state_q)
            TBL_SYNCED: begin
                if (wr_en && commit) begin
                    do_copy = 1'b1;
                end else if (wr_en) begin
                    state_d = TBL_PENDING;
                end
            end
            TBL_PENDING: begin
                if (commit) begin
                    do_copy = 1'b1;
                    state_d = TBL_SYNCED;
                end
            end
            default: state_d = TBL_SYNCED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TBL_SYNCED;
        end else begin
            state_q <= state_d;
        end
    end

    generate
        for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
            localparam logic [TW-1:0] DEF_TID = TW'(g % NUM_THREADS);
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    shd_tid[g] <= DEF_TID;
                    shd_on[g]  <= 1'b1;
                    act_tid[g] <= DEF_TID;
                    act_on[g]  <= 1'b1;
                end else begin
                    shd_tid[g] <= nxt_tid[g];
                    shd_on[g]  <= nxt_on[g];
                    if (do_copy) begin
                        act_tid[g] <= nxt_tid[g];
                        act_on[g]  <= nxt_on[g];
                    end
                end
            end
        end
    endgenerate

    assign rd_tid = act_tid[rd_idx];
    assign rd_on  = act_on[rd_idx];

endmodule

// File: rtl/bss_issue_stage.sv
module bss_issue_stage #(
    parameter int NUM_THREADS = 4,
    localparam int TW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   run_en,
    input  logic [NUM_THREADS-1:0] ready,
    input  logic [TW-1:0]          slot_tid,
    input  logic                   slot_on,
    output logic                   issue_valid,
    output logic [TW-1:0]          issue_tid,
    output logic [NUM_THREADS-1:0] hit_issue,
    output logic [NUM_THREADS-1:0] hit_bubble
);

    logic owner_ready;
    logic take;

    assign owner_ready = ready[slot_tid];
    assign take        = run_en && slot_on && owner_ready;

    always_comb begin
        hit_issue  = '0;
        hit_bubble = '0;
        if (run_en && slot_on) begin
            if (owner_ready) hit_issue[slot_tid]  = 1'b1;
            else             hit_bubble[slot_tid] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_valid <= 1'b0;
            issue_tid   <= '0;
        end else begin
            issue_valid <= take;
            issue_tid   <= take ? slot_tid : '0;
        end
    end

endmodule

// File: rtl/bss_thread_counters.sv
module bss_thread_counters #(
    parameter int NUM_THREADS = 4,
    parameter int CNT_W       = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_THREADS-1:0]       hit_issue,
    input  logic [NUM_THREADS-1:0]       hit_bubble,
    output logic [NUM_THREADS*CNT_W-1:0] cnt_issue,
    output logic [NUM_THREADS*CNT_W-1:0] cnt_bubble
);

    generate
        for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
            logic [CNT_W-1:0] iss_q;
            logic [CNT_W-1:0] bub_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    iss_q <= '0;
                    bub_q <= '0;
                end else begin
                    if (hit_issue[t])  iss_q <= iss_q + 1'b1;
                    if (hit_bubble[t]) bub_q <= bub_q + 1'b1;
                end
            end
            assign cnt_issue[t*CNT_W +: CNT_W]  = iss_q;
            assign cnt_bubble[t*CNT_W +: CNT_W] = bub_q;
        end
    endgenerate

endmodule

// File: rtl/barrel_slot_sched.sv
module barrel_slot_sched #(
    parameter int NUM_THREADS = 4,
    parameter int NUM_SLOTS   = 8,
    parameter int CNT_W       = 16,
    localparam int SW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int TW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         run_en,
    input  logic [NUM_THREADS-1:0]       thr_ready,
    input  logic                         tbl_wr_en,
    input  logic [SW-1:0]                tbl_wr_idx,
    input  logic [TW-1:0]                tbl_wr_tid,
    input  logic                         tbl_wr_on,
    output logic                         issue_valid,
    output logic [TW-1:0]                issue_tid,
    output logic [NUM_THREADS*CNT_W-1:0] cnt_issue,
    output logic [NUM_THREADS*CNT_W-1:0] cnt_bubble
);

    logic [SW-1:0]          slot_idx;
    logic                   at_boundary;
    logic [TW-1:0]          slot_tid;
    logic                   slot_on;
    logic [NUM_THREADS-1:0] hit_issue;
    logic [NUM_THREADS-1:0] hit_bubble;

    bss_slot_pointer #(.NUM_SLOTS(NUM_SLOTS)) u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (run_en),
        .slot_idx    (slot_idx),
        .at_boundary (at_boundary)
    );

    bss_slot_table #(.NUM_THREADS(NUM_THREADS), .NUM_SLOTS(NUM_SLOTS)) u_tbl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (tbl_wr_en),
        .wr_idx (tbl_wr_idx),
        .wr_tid (tbl_wr_tid),
        .wr_on  (tbl_wr_on),
        .commit (at_boundary),
        .rd_idx (slot_idx),
        .rd_tid (slot_tid),
        .rd_on  (slot_on)
    );

    bss_issue_stage #(.NUM_THREADS(NUM_THREADS)) u_iss (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (run_en),
        .ready       (thr_ready),
        .slot_tid    (slot_tid),
        .slot_on     (slot_on),
        .issue_valid (issue_valid),
        .issue_tid   (issue_tid),
        .hit_issue   (hit_issue),
        .hit_bubble  (hit_bubble)
    );

    bss_thread_counters #(.NUM_THREADS(NUM_THREADS), .CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_issue  (hit_issue),
        .hit_bubble (hit_bubble),
        .cnt_issue  (cnt_issue),
        .cnt_bubble (cnt_bubble)
    );

endmodule

// File: rtl/barrel_slot_sched_chk.sv
module barrel_slot_sched_chk #(
    parameter int NUM_THREADS = 4,
    parameter int NUM_SLOTS   = 8,
    parameter int CNT_W       = 16,
    localparam int SW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int TW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         run_en,
    input logic [NUM_THREADS-1:0]       thr_ready,
    input logic                         tbl_wr_en,
    input logic [SW-1:0]                tbl_wr_idx,
    input logic [TW-1:0]                tbl_wr_tid,
    input logic                         tbl_wr_on,
    input logic                         issue_valid,
    input logic [TW-1:0]                issue_tid,
    input logic [NUM_THREADS*CNT_W-1:0] cnt_issue,
    input logic [NUM_THREADS*CNT_W-1:0] cnt_bubble
);

    localparam int SUM_W = CNT_W + TW + 1;

    logic [NUM_THREADS-1:0] ready_q;
    logic                   run_q;
    logic [SUM_W-1:0]       iss_sum;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= '0;
            run_q   <= 1'b0;
        end else begin
            ready_q <= thr_ready;
            run_q   <= run_en;
        end
    end

    always_comb begin
        iss_sum = '0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            iss_sum = iss_sum + SUM_W'(cnt_issue[t*CNT_W +: CNT_W]);
        end
    end

    // R3: an issued thread was ready at the deciding edge
    p_issued_was_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> ready_q[issue_tid]);

    // R3: a bubble carries thread number 0
    p_bubble_tid_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |-> (issue_tid == '0));

    // R5: a stopped cycle never issues
    p_stopped_no_issue_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> !issue_valid);

    // R9: the issue counters grow by one exactly when an issue is shown
    p_issue_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (iss_sum == $past(iss_sum) + 1'b1));

    p_issue_count_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |-> (iss_sum == $past(iss_sum)));

    // R5: stopped cycles leave the lost-slot counters alone
    p_stopped_no_bubble_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> $stable(cnt_bubble));

endmodule

bind barrel_slot_sched barrel_slot_sched_chk #(
    .NUM_THREADS (NUM_THREADS),
    .NUM_SLOTS   (NUM_SLOTS),
    .CNT_W       (CNT_W)
) u_chk (.*);

// File: tb/barrel_slot_sched_bench.sv
module barrel_slot_sched_bench;

    localparam int NT = 4;
    localparam int NS = 8;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_en = 1'b0;
    logic [NT-1:0] thr_ready = '0;
    logic          tbl_wr_en = 1'b0;
    logic [2:0]    tbl_wr_idx = '0;
    logic [1:0]    tbl_wr_tid = '0;
    logic          tbl_wr_on = 1'b0;
    logic          issue_valid;
    logic [1:0]    issue_tid;
    logic [NT*CW-1:0] cnt_issue;
    logic [NT*CW-1:0] cnt_bubble;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    barrel_slot_sched u_barrel_slot_sched (
        .clk (clk), .rst_n (rst_n), .run_en (run_en), .thr_ready (thr_ready),
        .tbl_wr_en (tbl_wr_en), .tbl_wr_idx (tbl_wr_idx), .tbl_wr_tid (tbl_wr_tid),
        .tbl_wr_on (tbl_wr_on), .issue_valid (issue_valid), .issue_tid (issue_tid),
        .cnt_issue (cnt_issue), .cnt_bubble (cnt_bubble)
    );

    // {ready[3:0], expected valid, expected tid[1:0]} for slots 0..7, default table
    localparam logic [6:0] VEC [8] = '{
        {4'b1111, 1'b1, 2'd0},
        {4'b0000, 1'b0, 2'd0},
        {4'b0100, 1'b1, 2'd2},
        {4'b0111, 1'b0, 2'd0},
        {4'b0001, 1'b1, 2'd0},
        {4'b1101, 1'b0, 2'd0},
        {4'b0100, 1'b1, 2'd2},
        {4'b1000, 1'b1, 2'd3}
    };

    task automatic check_val(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; run_en = 1'b0; thr_ready = '0; tbl_wr_en = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive at the falling edge, let one rising edge pass, check at the next falling edge
    task automatic step(input logic [3:0] rdy, input logic run,
                        input logic ev, input logic [1:0] et, input string req);
        thr_ready = rdy;
        run_en    = run;
        @(posedge clk);
        @(negedge clk);
        tbl_wr_en = 1'b0;
        check_val({req, " valid"}, int'(issue_valid), int'(ev));
        check_val({req, " tid"}, int'(issue_tid), int'(et));
    endtask

    task automatic set_write(input logic [2:0] idx, input logic [1:0] tid, input logic on);
        tbl_wr_en = 1'b1; tbl_wr_idx = idx; tbl_wr_tid = tid; tbl_wr_on = on;
    endtask

    function automatic int iss_of(input int t);
        return int'(cnt_issue[t*CW +: CW]);
    endfunction

    function automatic int bub_of(input int t);
        return int'(cnt_bubble[t*CW +: CW]);
    endfunction

    initial begin
        while (cycles < 5000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        check_val("R1 valid after reset", int'(issue_valid), 0);
        check_val("R1 tid after reset", int'(issue_tid), 0);
        for (int t = 0; t < NT; t++) begin
            check_val("R1 issue counter", iss_of(t), 0);
            check_val("R1 bubble counter", bub_of(t), 0);
        end

        // R2 R3 R4: vector walk over one rotation of the default table
        for (int v = 0; v < NS; v++) begin
            step(VEC[v][6:3], 1'b1, VEC[v][2], VEC[v][1:0], "R3 R4 vector");
        end
        // R9: shares after the walk
        check_val("R9 issue t0", iss_of(0), 2);
        check_val("R9 issue t1", iss_of(1), 0);
        check_val("R9 issue t2", iss_of(2), 2);
        check_val("R9 issue t3", iss_of(3), 1);
        check_val("R9 bubble t0", bub_of(0), 0);
        check_val("R9 bubble t1", bub_of(1), 2);
        check_val("R9 bubble t3", bub_of(3), 1);

        // R5: stopped cycles bubble and the pointer holds at slot 0
        for (int k = 0; k < 3; k++) step(4'b1111, 1'b0, 1'b0, 2'd0, "R5 stopped");
        check_val("R5 no bubble counted t1", bub_of(1), 2);
        step(4'b1111, 1'b1, 1'b1, 2'd0, "R5 pointer held");

        // R2: default table with all ready, round robin over threads
        do_reset();
        for (int k = 0; k < 2 * NS; k++) step(4'b1111, 1'b1, 1'b1, 2'(k % NT), "R2 round robin");
        check_val("R2 share t1", iss_of(1), 4);

        // R7: a write is held until the rotation wraps
        do_reset();
        step(4'b1111, 1'b1, 1'b1, 2'd0, "R7 slot0");
        set_write(3'd2, 2'd3, 1'b1);
        step(4'b1111, 1'b1, 1'b1, 2'd1, "R7 slot1 during write");
        for (int s = 2; s < NS; s++) step(4'b1111, 1'b1, 1'b1, 2'(s % NT), "R7 old mapping kept");
        step(4'b1111, 1'b1, 1'b1, 2'd0, "R7 new rotation slot0");
        step(4'b1111, 1'b1, 1'b1, 2'd1, "R7 new rotation slot1");
        step(4'b1111, 1'b1, 1'b1, 2'd3, "R7 new mapping live");

        // R6: disabled slot gives a bubble; written while stopped at slot 0 it is live at once
        do_reset();
        set_write(3'd3, 2'd3, 1'b0);
        step(4'b1111, 1'b0, 1'b0, 2'd0, "R6 write while stopped");
        for (int s = 0; s < NS; s++) begin
            if (s == 3) step(4'b1111, 1'b1, 1'b0, 2'd0, "R6 disabled slot");
            else        step(4'b1111, 1'b1, 1'b1, 2'(s % NT), "R6 enabled slot");
        end
        check_val("R9 disabled slot not counted", bub_of(3), 0);
        check_val("R9 t3 single issue", iss_of(3), 1);

        // R8: thread 1 owns every slot, thread 0 owns none
        do_reset();
        for (int s = 0; s < NS; s++) begin
            set_write(3'(s), 2'd1, 1'b1);
            step(4'b0000, 1'b0, 1'b0, 2'd0, "R8 fill table");
        end
        step(4'b0001, 1'b1, 1'b0, 2'd0, "R3 R8 slot not stolen");
        for (int k = 0; k < 4; k++) step(4'b1111, 1'b1, 1'b1, 2'd1, "R8 sole owner");
        check_val("R8 slotless thread count", iss_of(0), 0);
        check_val("R8 owner count", iss_of(1), 4);
        check_val("R9 lost slot counted", bub_of(1), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule